// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Write Port

This block holds a 256-entry colour lookup table, each entry made of an 8-bit red, green and blue value. Software writes it over a small 16-byte register window of 32-bit words. A write to the index register selects the entry. Writes to the colour register then fill the three channels of that entry one after another. After the third channel is written, the index moves on to the next entry, so a whole palette can be loaded as one stream of colour writes.

A pixel path reads the table without a clock. It presents an 8-bit pixel index and gets back the 24-bit colour. It also gets the same colour packed into one of five output formats, chosen by a format select input. Register reads return zero.

The write sequencer is a three-state machine:
- **PH_RED**: the next colour write fills red. Its transition goes to PH_GRN.
- **PH_GRN**: the next colour write fills green. Its transition goes to PH_BLU.
- **PH_BLU**: the next colour write fills blue. Its transition goes back to PH_RED and increments the index.

An index-register write forces PH_RED from any state. That transition is the restart.

Top module: `clut_dac`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first write, every entry reads as red = green = blue = 0, except entry 255, which reads as 0xFF in all three channels. The sequencer starts in PH_RED with index 0.
- R2: A write (`bus_we` = 1) at `bus_addr` = 0 loads the entry index from `bus_wdata[31:24]` and puts the sequencer in PH_RED.
- R3: Writes at `bus_addr` = 4 load `bus_wdata[31:24]` into the red, then the green, then the blue channel of the current entry, in that order. Bits 23:0 of the word are ignored.
- R4: The colour write that fills blue increments the index by one, modulo 256, so 255 is followed by 0. The sequencer returns to PH_RED.
- R5: A write at any `bus_addr` other than 0 or 4 changes neither the table, the index nor the phase. Cycles with `bus_we` = 0 also change nothing.
- R6: `bus_rdata` is zero at all times.
- R7: `pix_rgb` is {red[23:16], green[15:8], blue[7:0]} of entry `pix_idx`, with no clock in the path. A colour write shows on it from the cycle after that write, not during the write cycle itself.
- R8: `pix_packed` encodes the selected entry according to `fmt_sel`:
  - 0: 8-bit, {r[7:5], g[7:5], b[7:6]}.
  - 1: 15-bit, {r[7:3], g[7:3], b[7:3]}.
  - 2: 16-bit, {r[7:3], g[7:2], b[7:3]}.
  - 3: {8'h00, r, g, b}.
  - 4: {8'h00, b, g, r}.
  - 5 to 7: zero.
  
  Each code is zero-extended to 32 bits.
- R9: An index-register write in the middle of a triplet abandons it. Channels already written keep their new values, and the next colour write fills red of the new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, active high |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 32 | Write word; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel index for lookup |
| fmt_sel | input | 3 | Packed output format code |
| pix_rgb | output | 24 | Colour of entry `pix_idx` |
| pix_packed | output | 32 | Colour of entry `pix_idx` in the selected format |

## Verification
The assertions check the sequencer on every cycle:
- an index write loads the index and restarts PH_RED;
- red moves to green without touching the index;
- blue returns to red and adds one;
- stray offsets and idle cycles leave the index and phase alone;
- the lookup output holds whenever no write happens and the pixel index is steady.

The table contents need the bench's reference model and its scenarios:
- the reset image of all 256 entries;
- the channel each data byte lands in;
- the wrap from 255 to 0;
- the remains of an abandoned triplet;
- the old-value-then-new-value timing around a write;
- each packed format.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Write sequencer phase; also names the channel the next colour write fills
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    // Packed output format codes
    typedef enum logic [2:0] {
        FMT_P8     = 3'd0,
        FMT_P15    = 3'd1,
        FMT_P16    = 3'd2,
        FMT_RGB32  = 3'd3,
        FMT_BGR32  = 3'd4
    } fmt_e;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int CH_W     = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int IDX_OFS  = 0,
    parameter int COL_OFS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              wr_en,
    output phase_e            wr_chan,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [CH_W-1:0]   wr_val,
    output phase_e            cur_phase,
    output logic [IDX_W-1:0]  cur_idx
);

    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_OFS);
    localparam logic [ADDR_W-1:0] COL_A = ADDR_W'(COL_OFS);

    phase_e            phase_q, phase_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [CH_W-1:0]   top_byte;
    logic              hit_idx, hit_col;
    logic              unused_low;

    assign top_byte   = bus_wdata[DATA_W-1 -: CH_W];
    assign unused_low = ^bus_wdata[DATA_W-CH_W-1:0];
    assign hit_idx    = bus_we && (bus_addr == IDX_A);
    assign hit_col    = bus_we && (bus_addr == COL_A);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    // Next state and outputs
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        wr_en   = 1'b0;
        if (hit_idx) begin
            idx_d   = IDX_W'(top_byte);
            phase_d = PH_RED;
        end else if (hit_col) begin
            wr_en = 1'b1;
            unique case (phase_q)
                PH_RED:  phase_d = PH_GRN;
                PH_GRN:  phase_d = PH_BLU;
                PH_BLU: begin
                    phase_d = PH_RED;
                    idx_d   = idx_q + 1'b1;
                end
                default: phase_d = PH_RED;
            endcase
        end
    end

    assign wr_chan   = phase_q;
    assign wr_idx    = idx_q;
    assign wr_val    = top_byte;
    assign cur_phase = phase_q;
    assign cur_idx   = idx_q;

endmodule

// File: rtl/clut_table.sv
module clut_table
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  phase_e            wr_chan,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CH_W-1:0]   wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [3*CH_W-1:0] rd_rgb
);

    localparam int DEPTH  = 1 << IDX_W;
    localparam int N_CH   = 3;

    logic [N_CH-1:0][CH_W-1:0] rd_ch;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [CH_W-1:0] mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= (i == DEPTH-1) ? {CH_W{1'b1}} : '0;
            end else if (wr_en && (int'(wr_chan) == c)) begin
                mem[wr_idx] <= wr_val;
            end
        end

        assign rd_ch[c] = mem[rd_idx];
    end

    // channel 0 red, 1 green, 2 blue
    assign rd_rgb = {rd_ch[0], rd_ch[1], rd_ch[2]};

endmodule

// File: rtl/clut_pack.sv
module clut_pack
    import clut_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [3*CH_W-1:0] rgb,
    input  logic [2:0]        fmt_sel,
    output logic [4*CH_W-1:0] packed_px
);

    localparam int OUT_W = 4 * CH_W;

    logic [CH_W-1:0] r, g, b;
    fmt_e            fmt;

    assign r   = rgb[3*CH_W-1 -: CH_W];
    assign g   = rgb[2*CH_W-1 -: CH_W];
    assign b   = rgb[CH_W-1   -: CH_W];
    assign fmt = fmt_e'(fmt_sel);

    always_comb begin
        unique case (fmt)
            FMT_P8:    packed_px = OUT_W'({r[CH_W-1 -: 3], g[CH_W-1 -: 3], b[CH_W-1 -: 2]});
            FMT_P15:   packed_px = OUT_W'({r[CH_W-1 -: 5], g[CH_W-1 -: 5], b[CH_W-1 -: 5]});
            FMT_P16:   packed_px = OUT_W'({r[CH_W-1 -: 5], g[CH_W-1 -: 6], b[CH_W-1 -: 5]});
            FMT_RGB32: packed_px = {{CH_W{1'b0}}, r, g, b};
            FMT_BGR32: packed_px = {{CH_W{1'b0}}, b, g, r};
            default:   packed_px = '0;
        endcase
    end

endmodule

// File: rtl/clut_dac.sv
module clut_dac
    import clut_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int CH_W    = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int IDX_OFS = 0,
    parameter int COL_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    input  logic [2:0]        fmt_sel,
    output logic [3*CH_W-1:0] pix_rgb,
    output logic [4*CH_W-1:0] pix_packed
);

    logic             wr_en;
    phase_e           wr_chan;
    logic [IDX_W-1:0] wr_idx;
    logic [CH_W-1:0]  wr_val;
    phase_e           cur_phase;
    logic [IDX_W-1:0] cur_idx;

    clut_seq #(
        .IDX_W(IDX_W), .CH_W(CH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .IDX_OFS(IDX_OFS), .COL_OFS(COL_OFS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_idx(wr_idx), .wr_val(wr_val),
        .cur_phase(cur_phase), .cur_idx(cur_idx)
    );

    clut_table #(.IDX_W(IDX_W), .CH_W(CH_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_idx(wr_idx), .wr_val(wr_val),
        .rd_idx(pix_idx), .rd_rgb(pix_rgb)
    );

    clut_pack #(.CH_W(CH_W)) u_pack (
        .rgb(pix_rgb), .fmt_sel(fmt_sel), .packed_px(pix_packed)
    );

    assign bus_rdata = '0;

endmodule

// File: rtl/clut_dac_chk.sv
module clut_dac_chk
    import clut_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int CH_W    = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int IDX_OFS = 0,
    parameter int COL_OFS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [IDX_W-1:0]  pix_idx,
    input logic [3*CH_W-1:0] pix_rgb,
    input phase_e            phase,
    input logic [IDX_W-1:0]  idx
);

    logic idx_wr, col_wr;
    assign idx_wr = bus_we && (bus_addr == ADDR_W'(IDX_OFS));
    assign col_wr = bus_we && (bus_addr == ADDR_W'(COL_OFS));

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx == $past(bus_wdata[DATA_W-1 -: IDX_W])) && (phase == PH_RED));

    // R3
    red_to_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && phase == PH_RED) |=> (phase == PH_GRN) && $stable(idx));

    // R3
    green_to_blue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && phase == PH_GRN) |=> (phase == PH_BLU) && $stable(idx));

    // R4
    blue_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && phase == PH_BLU) |=> (phase == PH_RED) && (idx == IDX_W'($past(idx) + 1'b1)));

    // R5
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_wr || col_wr) |=> $stable(idx) && $stable(phase));

    // R7
    lookup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> (!$stable(pix_idx) || $stable(pix_rgb)));

endmodule

bind clut_dac clut_dac_chk #(
    .IDX_W(IDX_W), .CH_W(CH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .IDX_OFS(IDX_OFS), .COL_OFS(COL_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
    .phase(cur_phase), .idx(cur_idx)
);

// File: tb/clut_dac_tb.sv
`timescale 1ns/100ps
module clut_dac_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [2:0]  fmt_sel = 3'd3;
    logic [23:0] pix_rgb;
    logic [31:0] pix_packed;

    always #2.5 clk = ~clk;

    clut_dac u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx),
        .fmt_sel(fmt_sel), .pix_rgb(pix_rgb), .pix_packed(pix_packed)
    );

    int cmp_n = 0;
    int bad_n = 0;
    bit done  = 0;

    // behavioural reference
    int m_r[256], m_g[256], m_b[256];
    int m_idx, m_ph;

    function automatic int exp_pack(int f, int r, int g, int b);
        case (f)
            0: return (r/32)*32 + (g/32)*4 + b/64;
            1: return (r/8)*1024 + (g/8)*32 + b/8;
            2: return (r/8)*2048 + (g/4)*32 + b/8;
            3: return r*65536 + g*256 + b;
            4: return b*65536 + g*256 + r;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        cmp_n++;
        if (act != exp) begin
            bad_n++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_r[i] = 0; m_g[i] = 0; m_b[i] = 0;
        end
        m_r[255] = 255; m_g[255] = 255; m_b[255] = 255;
        m_idx = 0; m_ph = 0;
    endtask

    task automatic model_edge();
        int v;
        v = int'(bus_wdata[31:24]);
        if (bus_we && bus_addr == 4'd0) begin
            m_idx = v; m_ph = 0;
        end else if (bus_we && bus_addr == 4'd4) begin
            case (m_ph)
                0: m_r[m_idx] = v;
                1: m_g[m_idx] = v;
                default: m_b[m_idx] = v;
            endcase
            m_ph = m_ph + 1;
            if (m_ph == 3) begin
                m_ph = 0;
                m_idx = (m_idx + 1) % 256;
            end
        end
    endtask

    // compare before the edge, then advance the model by one clock
    task automatic tick(string tag);
        int e;
        #1;
        e = int'(pix_idx);
        check(tag, "rdata (R6)", bus_rdata, 0);
        check(tag, "rgb", pix_rgb, m_r[e]*65536 + m_g[e]*256 + m_b[e]);
        check(tag, "packed", pix_packed,
              exp_pack(int'(fmt_sel), m_r[e], m_g[e], m_b[e]));
        @(posedge clk);
        #1;
        model_edge();
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] v, string tag);
        bus_we = 1'b1; bus_addr = a; bus_wdata = {v, 24'h5AC3E1};
        tick(tag);
        bus_we = 1'b0; bus_addr = 4'hF; bus_wdata = 32'hFFFF_FFFF;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad_n++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R6", "rdata in reset", bus_rdata, 0);
        pix_idx = 8'd255;
        #1 check("R1", "entry 255 during reset", pix_rgb, 24'hFFFFFF);
        rst_n = 1'b1;

        // R1: full reset image
        for (int i = 0; i < 256; i++) begin
            pix_idx = 8'(i);
            tick("R1");
        end
        fmt_sel = 3'd4; pix_idx = 8'd255; tick("R1");

        // R2, R3: fill entry 10, watching it; R7 old value during write
        fmt_sel = 3'd3; pix_idx = 8'd10;
        wr(4'd0, 8'd10, "R2");
        wr(4'd4, 8'h12, "R3");
        tick("R7");
        wr(4'd4, 8'h34, "R3");
        wr(4'd4, 8'h56, "R3");
        tick("R3");
        // R4: index advanced to 11
        pix_idx = 8'd11;
        wr(4'd4, 8'hA1, "R4");
        wr(4'd4, 8'hB2, "R4");
        wr(4'd4, 8'hC3, "R4");
        tick("R4");

        // R4: wrap 255 -> 0
        pix_idx = 8'd255;
        wr(4'd0, 8'd255, "R2");
        wr(4'd4, 8'h01, "R4");
        wr(4'd4, 8'h02, "R4");
        wr(4'd4, 8'h03, "R4");
        tick("R4");
        pix_idx = 8'd0;
        wr(4'd4, 8'h77, "R4");
        wr(4'd4, 8'h88, "R4");
        wr(4'd4, 8'h99, "R4");
        tick("R4");
        pix_idx = 8'd1; tick("R4");

        // R9: abandoned triplet
        pix_idx = 8'd20;
        wr(4'd0, 8'd20, "R9");
        wr(4'd4, 8'hEE, "R9");
        wr(4'd4, 8'hDD, "R9");
        wr(4'd0, 8'd30, "R9");
        tick("R9");
        pix_idx = 8'd30;
        wr(4'd4, 8'h11, "R9");
        wr(4'd4, 8'h22, "R9");
        wr(4'd4, 8'h33, "R9");
        tick("R9");
        pix_idx = 8'd20; tick("R9");

        // R5: stray offsets and idle strobes
        pix_idx = 8'd40;
        wr(4'd0, 8'd40, "R5");
        wr(4'd8, 8'hAA, "R5");
        wr(4'd12, 8'hAB, "R5");
        wr(4'd1, 8'hAC, "R5");
        wr(4'd5, 8'hAD, "R5");
        bus_addr = 4'd4; bus_wdata = 32'hCC00_0000; tick("R5");
        bus_addr = 4'd0; bus_wdata = 32'h0900_0000; tick("R5");
        wr(4'd4, 8'h44, "R5");
        tick("R5");
        pix_idx = 8'd41; tick("R5");

        // R8: every format on several entries
        for (int e = 0; e < 4; e++) begin
            pix_idx = (e == 0) ? 8'd10 : (e == 1) ? 8'd11 : (e == 2) ? 8'd255 : 8'd30;
            for (int f = 0; f < 8; f++) begin
                fmt_sel = 3'(f);
                tick("R8");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
        $finish;
    end

endmodule